// File: doc/BRIEF.md
# Memory-Mapped UART Register Port

This block sits between a processor's load/store port and two targets: data memory and a byte-wide UART. Every access is decoded by address. A small window of four word registers at the top of the address space reaches the UART. Every other address reaches data memory. Accesses that fall in the window never enable memory. Loads from the window return UART status or data. A store to the transmit register hands one byte to the UART.

The UART side has two valid/ready streams. On the receive stream the UART drives `rx_valid` and `rx_data`, and the port drives `rx_ready`. A byte is consumed in any cycle in which `rx_ready` is high. The port raises `rx_ready` for exactly the cycle of a load from the receive-data register. It does this whether or not `rx_valid` is set, so software should poll the status register first. On the transmit stream the port drives `tx_valid` and `tx_data`, and the UART drives `tx_ready`. The port raises `tx_valid` only in a cycle in which `tx_ready` is already high, so every strobe completes a transfer. A store issued while the transmitter is busy is dropped and is not retried.

UART read data is registered, so it appears in the cycle after the load, which is when a synchronous memory returns its data. In that cycle `cpu_rdata` carries the UART word. In every other cycle it passes `mem_rdata` through.

Top module: `uart_mmio_port`

## Requirements
- R1: When `cpu_addr` lies in 0xFFFF0000..0xFFFF000F, `mem_rd_en` and `mem_wr_en` stay low. At any other address they equal `cpu_rd_en` and `cpu_wr_en` in the same cycle.
- R2: In the cycle after a load from 0xFFFF0000, `cpu_rdata` equals `rx_valid` (as sampled at the load) in bit 0, with all other bits zero.
- R3: In the cycle after a load from 0xFFFF0004, `cpu_rdata` equals `rx_data` (as sampled at the load) in bits 7:0, with all other bits zero.
- R4: In the cycle after a load from 0xFFFF0008, `cpu_rdata` equals `tx_ready` (as sampled at the load) in bit 0, with all other bits zero.
- R5: `rx_ready` is high in exactly those cycles that carry a load from 0xFFFF0004.
- R6: A store to 0xFFFF000C while `tx_ready` is high raises `tx_valid` for that cycle, with `tx_data` equal to `cpu_wdata[7:0]`. The same store while `tx_ready` is low leaves `tx_valid` low.
- R7: A store to 0xFFFF0000, 0xFFFF0004 or 0xFFFF0008 raises neither `tx_valid`, `rx_ready` nor `mem_wr_en`. A load from 0xFFFF000C returns zero in the following cycle.
- R8: An access inside the window whose address bits 1:0 are nonzero reaches neither memory nor the UART: no enable and no strobe. A load of this kind returns zero in the following cycle.
- R9: In a cycle that does not follow a load from the window, `cpu_rdata` equals the current `mem_rdata`.
- R10: While `rst_n` is low, `mem_rd_en`, `mem_wr_en`, `rx_ready` and `tx_valid` stay low. After reset, `cpu_rdata` follows `mem_rdata` until the first window load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd_en | input | 1 | Load request this cycle |
| cpu_wr_en | input | 1 | Store request this cycle |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid the cycle after the load |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_rdata | input | 32 | Data memory read data |
| rx_valid | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Consume strobe to the receiver |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | Send strobe to the transmitter |
| tx_data | output | 8 | Byte to transmit |

## Verification
The bench goes after the window edges: the words just below 0xFFFF0000 and just above 0xFFFF000C, and misaligned addresses inside the window. A decoder that is too wide or too narrow would leak a store into memory or lose a memory load. The bench also stores to the transmit register while the transmitter is busy and stores to each read-only register. A design that ignores `tx_ready` or that decodes only part of the offset would then raise a stray `tx_valid`. The read path is checked in every cycle. This catches a mux that answers in the load cycle, or one that keeps returning a stale UART word in place of `mem_rdata`.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  localparam int PORT_ADDR_W = 32;
  localparam int PORT_DATA_W = 32;
  localparam int PORT_BYTE_W = 8;
  localparam logic [31:0] PORT_BASE = 32'hFFFF_0000;
  localparam int REG_COUNT = 4;
  localparam int REG_IDX_W = $clog2(REG_COUNT);

  typedef enum logic [REG_IDX_W-1:0] {
    REG_RX_STAT = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_STAT = 2'd2,
    REG_TX_DATA = 2'd3
  } uart_reg_e;
endpackage

// File: rtl/uart_mmio_decode.sv
module uart_mmio_decode
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = PORT_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = PORT_BASE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              reg_hit,
  output uart_reg_e         reg_sel
);
  localparam int WIN_LSB = REG_IDX_W + 2;

  // whole window, aligned or not, is withheld from memory
  assign win_hit = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  // only word-aligned offsets reach a register
  assign reg_hit = win_hit && (addr[1:0] == 2'b00);
  assign reg_sel = uart_reg_e'(addr[WIN_LSB-1:2]);
endmodule

// File: rtl/uart_mmio_strobe.sv
module uart_mmio_strobe
  import uart_mmio_pkg::*;
(
  input  logic      run,
  input  logic      rd_en,
  input  logic      wr_en,
  input  logic      win_hit,
  input  logic      reg_hit,
  input  uart_reg_e reg_sel,
  input  logic      tx_ready,
  output logic      mem_rd_en,
  output logic      mem_wr_en,
  output logic      rx_ready,
  output logic      tx_valid
);
  logic rd_req, wr_req;

  assign rd_req = run && rd_en;
  assign wr_req = run && wr_en;

  always_comb begin
    mem_rd_en = rd_req && !win_hit;
    mem_wr_en = wr_req && !win_hit;
    rx_ready  = 1'b0;
    tx_valid  = 1'b0;
    if (reg_hit) begin
      unique case (reg_sel)
        REG_RX_DATA: rx_ready = rd_req;
        REG_TX_DATA: tx_valid = wr_req && tx_ready;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_rdpath.sv
module uart_mmio_rdpath
  import uart_mmio_pkg::*;
#(
  parameter int DATA_W = PORT_DATA_W,
  parameter int BYTE_W = PORT_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              win_hit,
  input  logic              reg_hit,
  input  uart_reg_e         reg_sel,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] reg_word [REG_COUNT];
  logic [DATA_W-1:0] word_d, word_q;
  logic              sel_q;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
    if (g == int'(REG_RX_STAT)) begin : g_rxs
      assign reg_word[g] = {{(DATA_W-1){1'b0}}, rx_valid};
    end else if (g == int'(REG_RX_DATA)) begin : g_rxd
      assign reg_word[g] = {{(DATA_W-BYTE_W){1'b0}}, rx_data};
    end else if (g == int'(REG_TX_STAT)) begin : g_txs
      assign reg_word[g] = {{(DATA_W-1){1'b0}}, tx_ready};
    end else begin : g_wo
      assign reg_word[g] = '0;
    end
  end

  assign word_d = reg_hit ? reg_word[reg_sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sel_q <= rd_en && win_hit;
      if (rd_en && win_hit) word_q <= word_d;
    end
  end

  assign rdata = sel_q ? word_q : mem_rdata;
endmodule

// File: rtl/uart_mmio_port.sv
module uart_mmio_port
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = PORT_ADDR_W,
  parameter int DATA_W = PORT_DATA_W,
  parameter int BYTE_W = PORT_BYTE_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = PORT_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd_en,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  logic      win_hit, reg_hit;
  uart_reg_e reg_sel;
  logic      wdata_hi_unused;

  uart_mmio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(cpu_addr), .win_hit(win_hit), .reg_hit(reg_hit), .reg_sel(reg_sel)
  );

  uart_mmio_strobe u_stb (
    .run(rst_n), .rd_en(cpu_rd_en), .wr_en(cpu_wr_en),
    .win_hit(win_hit), .reg_hit(reg_hit), .reg_sel(reg_sel),
    .tx_ready(tx_ready), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .rx_ready(rx_ready), .tx_valid(tx_valid)
  );

  uart_mmio_rdpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(cpu_rd_en),
    .win_hit(win_hit), .reg_hit(reg_hit), .reg_sel(reg_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .mem_rdata(mem_rdata), .rdata(cpu_rdata)
  );

  assign tx_data = cpu_wdata[BYTE_W-1:0];
  assign wdata_hi_unused = ^cpu_wdata[DATA_W-1:BYTE_W];
endmodule

// File: rtl/uart_mmio_port_chk.sv
module uart_mmio_port_chk
  import uart_mmio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cpu_addr,
  input logic        cpu_rd_en,
  input logic        cpu_wr_en,
  input logic [31:0] cpu_rdata,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_ready,
  input logic        tx_ready,
  input logic        tx_valid
);
  logic in_win;
  assign in_win = (cpu_addr[31:4] == PORT_BASE[31:4]);

  AST_WIN_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (!mem_rd_en && !mem_wr_en)); // R1

  AST_RX_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && cpu_addr == 32'hFFFF_0000) |=> (cpu_rdata == {31'd0, $past(rx_valid)})); // R2

  AST_RX_DATA_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && cpu_addr == 32'hFFFF_0004) |=> (cpu_rdata == {24'd0, $past(rx_data)})); // R3

  AST_CONSUME_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (cpu_rd_en && cpu_addr == 32'hFFFF_0004)); // R5

  AST_SEND_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_ready && cpu_wr_en && cpu_addr == 32'hFFFF_000C)); // R6

  always_comb begin
    if (rst_n == 1'b0) begin
      AST_QUIET_IN_RESET: assert (!mem_rd_en && !mem_wr_en && !rx_ready && !tx_valid); // R10
    end
  end
endmodule

bind uart_mmio_port uart_mmio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_en(cpu_rd_en),
  .cpu_wr_en(cpu_wr_en), .cpu_rdata(cpu_rdata), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_ready(rx_ready), .tx_ready(tx_ready), .tx_valid(tx_valid)
);

// File: tb/sim_uart_mmio_port.sv
module sim_uart_mmio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd_en = 1'b0, cpu_wr_en = 1'b0;
  logic [31:0] cpu_wdata = '0, mem_rdata = '0;
  logic [31:0] cpu_rdata;
  logic        mem_rd_en, mem_wr_en, rx_ready, tx_valid;
  logic        rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0, tx_data;

  int checks = 0, errors = 0, seed_val;
  logic        prev_win_rd = 1'b0;
  logic [31:0] prev_word = '0;
  string       prev_tag = "R9";

  uart_mmio_port u0 (.*);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: R9 run hung, actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic in_win(input logic [31:0] a);
    return a[31:4] == 28'hFFFF000;
  endfunction
  function automatic logic is_reg(input logic [31:0] a);
    return in_win(a) && a[1:0] == 2'b00;
  endfunction
  function automatic logic [31:0] exp_word(input logic [31:0] a);
    if (!is_reg(a)) return 32'd0;
    case (a[3:2])
      2'd0: return {31'd0, rx_valid};
      2'd1: return {24'd0, rx_data};
      2'd2: return {31'd0, tx_ready};
      default: return 32'd0;
    endcase
  endfunction
  function automatic string read_tag(input logic [31:0] a);
    if (!is_reg(a)) return "R8";
    case (a[3:2])
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h addr=%h", tag, act, exp, cpu_addr);
    end
  endtask

  // drive at negedge; combinational and read-path checks 2 ns later
  task automatic step(input logic [31:0] a, input logic rd, input logic wr,
                      input logic [31:0] wd, input logic rv, input logic [7:0] rdat,
                      input logic tr, input logic [31:0] md);
    logic w, h, ro_wr;
    @(negedge clk);
    cpu_addr = a; cpu_rd_en = rd; cpu_wr_en = wr; cpu_wdata = wd;
    rx_valid = rv; rx_data = rdat; tx_ready = tr; mem_rdata = md;
    #2;
    w = in_win(a); h = is_reg(a);
    ro_wr = wr && h && a[3:2] != 2'd3;
    if (prev_win_rd) check({prev_tag, " R9 registered word"}, cpu_rdata, prev_word);
    else             check("R9 memory pass", cpu_rdata, md);
    check(w ? (h ? "R1 window rd" : "R8 misaligned rd") : "R1 mem rd", {31'd0, mem_rd_en}, {31'd0, rd && !w});
    check(ro_wr ? "R7 wr read-only" : (w ? "R1 window wr" : "R1 mem wr"),
          {31'd0, mem_wr_en}, {31'd0, wr && !w});
    check(h ? "R5 consume" : "R8 consume", {31'd0, rx_ready}, {31'd0, rd && h && a[3:2] == 2'd1});
    check(ro_wr ? "R7 send" : (h ? "R6 send" : "R8 send"), {31'd0, tx_valid},
          {31'd0, wr && h && a[3:2] == 2'd3 && tr});
    if (wr && h && a[3:2] == 2'd3 && tr) check("R6 tx byte", {24'd0, tx_data}, {24'd0, wd[7:0]});
    prev_win_rd = rd && w;
    prev_word   = exp_word(a);
    prev_tag    = read_tag(a);
  endtask

  initial begin
    seed_val = 32'h5EED;
    void'($urandom(seed_val));
    // reset: requests held high, nothing must leak
    cpu_addr = 32'hFFFF_000C; cpu_wr_en = 1'b1; cpu_rd_en = 1'b1; tx_ready = 1'b1;
    mem_rdata = 32'hCAFE_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R10 rx_ready", {31'd0, rx_ready}, 32'd0);
    check("R10 mem_wr_en", {31'd0, mem_wr_en}, 32'd0);
    check("R10 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
    cpu_addr = 32'h0000_0100;
    #1 check("R10 rdata pass", cpu_rdata, 32'hCAFE_0001);
    cpu_rd_en = 1'b0; cpu_wr_en = 1'b0;
    rst_n = 1'b1;

    // directed corners
    step(32'hFFFF_000C, 0, 1, 32'h1234_56A5, 0, 8'h00, 0, 32'h11);   // R6 busy drop
    step(32'hFFFF_000C, 0, 1, 32'hFFFF_FF3C, 0, 8'h00, 1, 32'h12);   // R6 send
    step(32'hFFFF_0000, 0, 1, 32'hFFFF_FFFF, 1, 8'h77, 1, 32'h13);   // R7
    step(32'hFFFF_0004, 0, 1, 32'hFFFF_FFFF, 1, 8'h77, 1, 32'h14);   // R7
    step(32'hFFFF_0008, 0, 1, 32'hFFFF_FFFF, 1, 8'h77, 1, 32'h15);   // R7
    step(32'hFFFF_0004, 1, 0, 32'h0, 1, 8'hA9, 0, 32'h16);           // R3, R5
    step(32'hFFFF_0000, 1, 0, 32'h0, 1, 8'h00, 0, 32'h17);           // R2
    step(32'hFFFF_0008, 1, 0, 32'h0, 0, 8'h00, 1, 32'h18);           // R4
    step(32'hFFFF_000C, 1, 0, 32'h0, 1, 8'hFF, 1, 32'h19);           // R7 read zero
    step(32'hFFFF_0006, 1, 0, 32'h0, 1, 8'hFF, 1, 32'h1A);           // R8
    step(32'hFFFF_000F, 0, 1, 32'hFF, 1, 8'hFF, 1, 32'h1B);          // R8
    step(32'hFFFF_0010, 1, 0, 32'h0, 1, 8'hFF, 1, 32'h1C);           // R1 above
    step(32'hFFFE_FFFC, 0, 1, 32'h5, 1, 8'hFF, 1, 32'h1D);           // R1 below
    step(32'h0000_0040, 0, 0, 32'h0, 0, 8'h00, 0, 32'h1E);           // R9

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      int sel, op;
      sel = int'($urandom_range(0, 7));
      op  = int'($urandom_range(0, 2));
      case (sel)
        0, 1, 2, 3: a = 32'hFFFF_0000 + 32'(sel * 4);
        4: a = 32'hFFFF_0000 + 32'($urandom_range(0, 15));
        5: a = 32'hFFFF_0010 + 32'($urandom_range(0, 3) * 4);
        6: a = 32'hFFFE_FFF0 + 32'($urandom_range(0, 3) * 4);
        default: begin
          a = $urandom();
          if (in_win(a)) a = a ^ 32'h8000_0000;
        end
      endcase
      step(a, op == 1, op == 2, $urandom(), 1'($urandom()), 8'($urandom()),
           1'($urandom()), $urandom());
    end
    step(32'h0000_0000, 0, 0, 32'h0, 0, 8'h00, 0, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule